// File: doc/BRIEF.md
# Dual-Mode Dual-Clock FIFO

This block moves words from a write clock domain to an independent read clock domain through a register-array queue. The output behaviour is picked while master reset is low. In standard mode each word, the first one included, leaves only when the reader asks for it with an active-low read enable. In fall-through mode the oldest word moves into the output register on its own, and read enable only advances to the next word. The output register holds one word of its own, so fall-through mode stores one word more than the array depth.

Two status outputs change their meaning with the mode. `full_ir` is an active-low full flag in standard mode. In fall-through mode it is an input-ready flag that is high when no space is left. `empty_or` is an active-low empty flag in standard mode. In fall-through mode it is high while the output register holds no valid word. Each pointer crosses to the other domain in Gray code through two flops, so each flag sees the other side's activity two of its own clock edges late. A partial reset empties the queue and keeps the chosen mode.

The read side is a state machine with three states. `RS_STD` serves standard mode. `RS_FW_EMPTY` means the fall-through output register holds no word. `RS_FW_VALID` means it holds one. The transitions are:
- LOAD_FIRST goes from `RS_FW_EMPTY` to `RS_FW_VALID` when the array has a word.
- REFILL stays in `RS_FW_VALID` on a read while the array still has words.
- DRAIN goes from `RS_FW_VALID` to `RS_FW_EMPTY` on a read with the array empty.
- Master reset enters `RS_STD` or `RS_FW_EMPTY` from the mode pin. Partial reset enters the same state from the stored mode.

Top module: `dual_mode_fifo`

## Requirements
- R1: After master reset, standard mode shows `full_ir`=1 and `empty_or`=0, and fall-through mode shows `full_ir`=0 and `empty_or`=1. In both modes `rd_data` is 0.
- R2: A word is stored on a rising `wr_clk` edge only when `wr_en_n`=0 and the queue is not full. A write attempted while full is dropped and never comes out.
- R3: In standard mode `full_ir` goes to 0 on the write edge that stores the DEPTH-th word with no reads. After a read it returns to 1 on the second `wr_clk` edge after that read edge.
- R4: In fall-through mode `full_ir` stays 0 after DEPTH stored words (array plus output register) and goes to 1 on the edge that stores word DEPTH+1.
- R5: In standard mode `empty_or` rises to 1 on the second `rd_clk` edge after the write edge that stores a word into an empty queue.
- R6: In standard mode a word reaches `rd_data` only on a `rd_clk` edge with `rd_en_n`=0. `empty_or` drops to 0 on the edge that reads the last word. A read while empty leaves `rd_data` unchanged.
- R7: In fall-through mode, the first word written into an empty queue appears on `rd_data` on the third `rd_clk` edge after its write edge, with `rd_en_n` held at 1. On that same edge `empty_or` falls to 0.
- R8: In fall-through mode, a `rd_clk` edge with `rd_en_n`=0 and no further stored word sets `empty_or` to 1 and keeps the last word on `rd_data`. Later reads do not change it.
- R9: While `rd_en_n`=1, `rd_data` keeps its value, except when a fall-through word loads into an empty output register.
- R10: The mode is taken from `fwft_sel` only while `mrst_n`=0. A partial reset (`prst_n`=0) empties the queue, clears `rd_data` to 0 and keeps the mode.
- R11: Words leave in the order in which they were stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_en_n | input | 1 | Active-low write enable |
| wr_data | input | DATA_W | Write data |
| rd_clk | input | 1 | Read-domain clock |
| rd_en_n | input | 1 | Active-low read enable |
| rd_data | output | DATA_W | Registered read data |
| fwft_sel | input | 1 | 1 selects fall-through mode; sampled during master reset |
| mrst_n | input | 1 | Active-low master reset, synchronous in each domain |
| prst_n | input | 1 | Active-low partial reset, keeps the mode |
| full_ir | output | 1 | Full (active low) or input-ready (high = no space) |
| empty_or | output | 1 | Empty (active low) or output-ready (high = no valid word) |

## Verification
Every result has a fixed due edge:
- Write-side fullness is due on the write edge itself, and its release after a read on the second write edge.
- Standard-mode non-empty is due on the second read edge after the write.
- A fall-through first word is due on the third read edge.
- A requested read lands on the read edge that samples the enable.

The bench offsets the read clock by half a period from the write clock. It drives and samples one nanosecond after the edge that matters, and it counts edges with explicit waits. Each flag is therefore checked once before its due edge and once on it. A scoreboard queue holds the words that should come out, and dropped writes are never pushed to it.

// File: rtl/fifo_pkg.sv
package fifo_pkg;

    // Read-side controller states
    typedef enum logic [1:0] {
        RS_STD      = 2'd0,
        RS_FW_EMPTY = 2'd1,
        RS_FW_VALID = 2'd2
    } rd_state_t;

endpackage

// File: rtl/fifo_mem.sv
module fifo_mem #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/gray_sync.sv
module gray_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/fifo_wr_ctl.sv
module fifo_wr_ctl #(
    parameter int ADDR_W = 4
) (
    input  logic            clk,
    input  logic            mrst_n,
    input  logic            prst_n,
    input  logic            fwft_sel,
    input  logic            wr_en_n,
    input  logic [ADDR_W:0] rgray_s,
    output logic [ADDR_W:0] wptr,
    output logic [ADDR_W:0] wgray,
    output logic            wr_fire,
    output logic            full_ir
);
    localparam logic [ADDR_W:0] FULL_FILL = {1'b1, {ADDR_W{1'b0}}};

    logic            rst_n;
    logic            mode_q;
    logic [ADDR_W:0] rbin;
    logic [ADDR_W:0] fill;
    logic [ADDR_W:0] wptr_nxt;
    logic            ram_full;

    assign rst_n = mrst_n & prst_n;

    // Mode capture: only while master reset is low
    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            mode_q <= fwft_sel;
        end
    end

    always_comb begin
        rbin[ADDR_W] = rgray_s[ADDR_W];
        for (int i = ADDR_W - 1; i >= 0; i--) begin
            rbin[i] = rbin[i+1] ^ rgray_s[i];
        end
    end

    assign fill     = wptr - rbin;
    assign ram_full = (fill == FULL_FILL);
    assign wr_fire  = rst_n && !wr_en_n && !ram_full;
    assign wptr_nxt = wptr + {{ADDR_W{1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            wgray <= '0;
        end else if (wr_fire) begin
            wptr  <= wptr_nxt;
            wgray <= wptr_nxt ^ (wptr_nxt >> 1);
        end
    end

    assign full_ir = mode_q ? ram_full : !ram_full;

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= FULL_FILL);

    // R2
    full_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_full |=> wptr == $past(wptr));

    // R11
    gray_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wgray ^ $past(wgray)) <= 1);
endmodule

// File: rtl/fifo_rd_ctl.sv
module fifo_rd_ctl
    import fifo_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              mrst_n,
    input  logic              prst_n,
    input  logic              fwft_sel,
    input  logic              rd_en_n,
    input  logic [ADDR_W:0]   wgray_s,
    input  logic [DATA_W-1:0] mem_q,
    output logic [ADDR_W:0]   rptr,
    output logic [ADDR_W:0]   rgray,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty_or
);
    localparam logic [ADDR_W:0] FULL_FILL = {1'b1, {ADDR_W{1'b0}}};

    rd_state_t       state, state_nxt;
    logic            rst_n;
    logic            mode_q;
    logic [ADDR_W:0] wbin;
    logic [ADDR_W:0] rptr_nxt;
    logic            ram_empty;
    logic            take;

    assign rst_n = mrst_n & prst_n;

    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            mode_q <= fwft_sel;
        end
    end

    always_comb begin
        wbin[ADDR_W] = wgray_s[ADDR_W];
        for (int i = ADDR_W - 1; i >= 0; i--) begin
            wbin[i] = wbin[i+1] ^ wgray_s[i];
        end
    end

    assign ram_empty = (rptr == wbin);
    assign rptr_nxt  = rptr + {{ADDR_W{1'b0}}, 1'b1};

    // Next state and array fetch decision
    always_comb begin
        state_nxt = state;
        take      = 1'b0;
        unique case (state)
            RS_STD: begin
                take = !rd_en_n && !ram_empty;
            end
            RS_FW_EMPTY: begin
                if (!ram_empty) begin          // LOAD_FIRST
                    take      = 1'b1;
                    state_nxt = RS_FW_VALID;
                end
            end
            RS_FW_VALID: begin
                if (!rd_en_n) begin
                    if (!ram_empty) begin      // REFILL
                        take = 1'b1;
                    end else begin             // DRAIN
                        state_nxt = RS_FW_EMPTY;
                    end
                end
            end
            default: state_nxt = RS_STD;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            state <= fwft_sel ? RS_FW_EMPTY : RS_STD;
        end else if (!prst_n) begin
            state <= mode_q ? RS_FW_EMPTY : RS_STD;
        end else begin
            state <= state_nxt;
        end
    end

    // Output register and pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr    <= '0;
            rgray   <= '0;
            rd_data <= '0;
        end else if (take) begin
            rptr    <= rptr_nxt;
            rgray   <= rptr_nxt ^ (rptr_nxt >> 1);
            rd_data <= mem_q;
        end
    end

    assign empty_or = (state == RS_STD) ? !ram_empty : (state != RS_FW_VALID);

    // R6
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_empty |=> rptr == $past(rptr));

    // R11
    occupancy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wbin - rptr) <= FULL_FILL);

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_n && state != RS_FW_EMPTY) |=> $stable(rd_data));

    // R7
    wait_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RS_FW_EMPTY && ram_empty) |=> (state == RS_FW_EMPTY));
endmodule

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              wr_clk,
    input  logic              wr_en_n,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_clk,
    input  logic              rd_en_n,
    output logic [DATA_W-1:0] rd_data,
    input  logic              fwft_sel,
    input  logic              mrst_n,
    input  logic              prst_n,
    output logic              full_ir,
    output logic              empty_or
);
    localparam int PW = ADDR_W + 1;

    logic            rst_n;
    logic [PW-1:0]   wptr, wgray, wgray_s;
    logic [PW-1:0]   rptr, rgray, rgray_s;
    logic            wr_fire;
    logic [DATA_W-1:0] mem_q;

    assign rst_n = mrst_n & prst_n;

    fifo_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .clk   (wr_clk),
        .we    (wr_fire),
        .waddr (wptr[ADDR_W-1:0]),
        .wdata (wr_data),
        .raddr (rptr[ADDR_W-1:0]),
        .rdata (mem_q)
    );

    gray_sync #(.W(PW)) u_w2r (
        .clk   (rd_clk),
        .rst_n (rst_n),
        .d     (wgray),
        .q     (wgray_s)
    );

    gray_sync #(.W(PW)) u_r2w (
        .clk   (wr_clk),
        .rst_n (rst_n),
        .d     (rgray),
        .q     (rgray_s)
    );

    fifo_wr_ctl #(.ADDR_W(ADDR_W)) u_wr (
        .clk      (wr_clk),
        .mrst_n   (mrst_n),
        .prst_n   (prst_n),
        .fwft_sel (fwft_sel),
        .wr_en_n  (wr_en_n),
        .rgray_s  (rgray_s),
        .wptr     (wptr),
        .wgray    (wgray),
        .wr_fire  (wr_fire),
        .full_ir  (full_ir)
    );

    fifo_rd_ctl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
        .clk      (rd_clk),
        .mrst_n   (mrst_n),
        .prst_n   (prst_n),
        .fwft_sel (fwft_sel),
        .rd_en_n  (rd_en_n),
        .wgray_s  (wgray_s),
        .mem_q    (mem_q),
        .rptr     (rptr),
        .rgray    (rgray),
        .rd_data  (rd_data),
        .empty_or (empty_or)
    );
endmodule

// File: tb/dual_mode_fifo_bench.sv
`timescale 1ns/1ps
module dual_mode_fifo_bench;
    localparam int DW = 8;
    localparam int AW = 4;
    localparam int DEPTH = 1 << AW;

    logic          wr_clk, rd_clk;
    logic          wr_en_n = 1'b1, rd_en_n = 1'b1;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          fwft_sel = 1'b0, mrst_n = 1'b0, prst_n = 1'b1;
    logic          full_ir, empty_or;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    logic [DW-1:0] exp_q [$];

    dual_mode_fifo #(.DATA_W(DW), .ADDR_W(AW)) u_dual_mode_fifo (
        .wr_clk(wr_clk), .wr_en_n(wr_en_n), .wr_data(wr_data),
        .rd_clk(rd_clk), .rd_en_n(rd_en_n), .rd_data(rd_data),
        .fwft_sel(fwft_sel), .mrst_n(mrst_n), .prst_n(prst_n),
        .full_ir(full_ir), .empty_or(empty_or)
    );

    // 250 MHz; read clock lags by half a period
    initial begin
        wr_clk = 1'b0;
        forever #2 wr_clk = ~wr_clk;
    end
    initial begin
        rd_clk = 1'b1;
        forever #2 rd_clk = ~rd_clk;
    end

    task automatic report();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #400000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        report();
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wsync(); @(posedge wr_clk); #1; endtask
    task automatic rsync(); @(posedge rd_clk); #1; endtask

    // Driver: one write cycle; pushes what should come out
    task automatic wr_word(logic [DW-1:0] d, bit accepted);
        wr_data = d; wr_en_n = 1'b0;
        @(posedge wr_clk); #1;
        wr_en_n = 1'b1;
        if (accepted) exp_q.push_back(d);
    endtask

    task automatic rd_word();
        rd_en_n = 1'b0;
        @(posedge rd_clk); #1;
        rd_en_n = 1'b1;
    endtask

    // Monitor: compares the output against the scoreboard head
    task automatic check_pop(string req);
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        check(req, rd_data, e);
    endtask

    task automatic do_mreset(bit m);
        wr_en_n = 1'b1; rd_en_n = 1'b1;
        fwft_sel = m; mrst_n = 1'b0;
        repeat (4) @(posedge wr_clk);
        #1 mrst_n = 1'b1;
        exp_q.delete();
    endtask

    task automatic do_preset();
        fwft_sel = 1'b0;               // must be ignored (R10)
        prst_n = 1'b0;
        repeat (4) @(posedge wr_clk);
        #1 prst_n = 1'b1;
        exp_q.delete();
    endtask

    initial begin
        // ---------------- standard mode ----------------
        do_mreset(1'b0);
        check("R1 std full_ir", full_ir, 1);
        check("R1 std empty_or", empty_or, 0);
        check("R1 std rd_data", rd_data, 0);

        wr_word(8'hA5, 1);
        rsync(); check("R5 first rd edge", empty_or, 0);
        rsync(); check("R5 second rd edge", empty_or, 1);
        check("R6 no unrequested data", rd_data, 0);
        rd_word(); check_pop("R6 requested word");
        check("R6 empty after last", empty_or, 0);
        rd_word(); check("R6 empty read ignored", rd_data, 8'hA5);

        wsync();
        for (int i = 0; i < DEPTH; i++) begin
            wr_word(8'h10 + 8'(i), 1);
            if (i == DEPTH - 2) check("R3 not full yet", full_ir, 1);
        end
        check("R3 full after DEPTH", full_ir, 0);
        wr_word(8'hEE, 0);
        check("R2 still full", full_ir, 0);

        rsync(); rd_word(); check_pop("R11 head word");
        wsync(); check("R3 full one wr edge after read", full_ir, 0);
        wsync(); check("R3 free two wr edges after read", full_ir, 1);

        rsync(); rsync(); rsync();
        check("R9 hold std", rd_data, 8'h10);
        for (int i = 1; i < DEPTH; i++) begin
            rd_word(); check_pop("R11 std order");
        end
        check("R6 empty after drain", empty_or, 0);
        repeat (4) rsync();
        check("R2 dropped word absent", empty_or, 0);
        rd_word(); check("R2 data unchanged", rd_data, 8'h1F);

        // ---------------- fall-through mode ----------------
        do_mreset(1'b1);
        check("R1 fwft full_ir", full_ir, 0);
        check("R1 fwft empty_or", empty_or, 1);
        check("R1 fwft rd_data", rd_data, 0);

        wr_word(8'h31, 1);
        rsync(); check("R7 edge1 empty_or", empty_or, 1);
        rsync(); check("R7 edge2 empty_or", empty_or, 1);
        check("R7 edge2 rd_data", rd_data, 0);
        rsync(); check("R7 edge3 empty_or", empty_or, 0);
        check_pop("R7 edge3 word");

        wsync(); wr_word(8'h32, 1); wr_word(8'h33, 1);
        repeat (4) rsync();
        check("R9 hold fwft", rd_data, 8'h31);
        rd_word(); check_pop("R11 fwft order");
        rd_word(); check_pop("R11 fwft order");
        rd_word();
        check("R8 output-ready drops", empty_or, 1);
        check("R8 last word kept", rd_data, 8'h33);
        rd_word();
        check("R8 read ignored flag", empty_or, 1);
        check("R8 read ignored data", rd_data, 8'h33);

        wsync();
        for (int i = 0; i <= DEPTH; i++) begin
            wr_word(8'h40 + 8'(i), 1);
            if (i == DEPTH - 1) check("R4 room at DEPTH", full_ir, 0);
        end
        check("R4 no room at DEPTH+1", full_ir, 1);
        wr_word(8'h99, 0);
        check("R2 fwft still full", full_ir, 1);
        repeat (4) rsync();
        check_pop("R4 head in output register");
        for (int i = 0; i < DEPTH; i++) begin
            rd_word(); check_pop("R11 fwft burst order");
        end
        rd_word();
        check("R2 fwft dropped word absent", empty_or, 1);
        check("R2 fwft last data", rd_data, 8'h50);

        // ---------------- partial reset ----------------
        wsync(); wr_word(8'h77, 0);
        repeat (4) rsync();
        do_preset();
        check("R10 mode kept full_ir", full_ir, 0);
        check("R10 mode kept empty_or", empty_or, 1);
        check("R10 rd_data cleared", rd_data, 0);
        wsync(); wr_word(8'h78, 1);
        rsync(); rsync(); rsync();
        check("R10 fall-through after partial reset", empty_or, 0);
        check_pop("R10 word");

        report();
    end
endmodule